// File: doc/BRIEF.md
# Radix-4 Recoded Unsigned Multiplier

This block multiplies two unsigned N-bit integers and returns the full 2N-bit product. The default width is 64. It does not build one gated row for every bit of the multiplier. Instead, the second operand is recoded into overlapping three-bit windows. Each window chooses a signed multiple of the first operand from 0, ±A and ±2A. The number of rows therefore drops to (N+2)/2 under integer division, which gives 33 rows when N is 64. One extra row is needed because the operand is unsigned.

Every row is sign-extended to 2N bits and shifted into place. A negative multiple is formed by inverting the positive multiple. The matching +1 is not added in the row. It is collected in a separate correction vector, and that vector enters the reduction together with the rows. All vectors are compressed in carry-save form into one sum word and one carry word. A single carry-propagate addition at the end produces the product, which is registered.

Operands are presented together with `in_valid`. The product appears exactly one clock later, flagged by `out_valid`. The product register keeps its value in cycles without an accepted operand pair.

Top module: `booth_mul`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid` and `p` to zero at the next rising clock edge.
- R2: `out_valid` is high in the cycle right after a rising edge at which `in_valid` was high, and low in the cycle after one at which it was low.
- R3: When `out_valid` is high, `p` equals the exact unsigned 2N-bit product of the `a` and `b` sampled one edge earlier. No bit of the product is dropped.
- R4: After an edge at which `in_valid` is low, `p` keeps its previous value.
- R5: Window i is the three bits {b[2i+1], b[2i], b[2i-1]}, with b[-1] taken as 0 and b zero-extended at the top. The windows map to multiples as follows: 000 and 111 select 0; 001 and 010 select +A; 011 selects +2A; 100 selects -2A; 101 and 110 select -A. A window never selects A and 2A at once.
- R6: Operands that force the topmost window to a nonzero multiple, such as all-ones for both, produce the correct full-width product (2^N-1)^2.
- R7: Multiplier patterns that produce negative multiples in many windows produce correct products. Examples are alternating 1010… and 0101… bit patterns and runs of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `a` and `b` are accepted at this edge |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned; the recoded operand |
| out_valid | output | 1 | `p` holds a fresh product |
| p | output | 2N | Full unsigned product |

## Verification
Each product and its valid flag are due exactly one rising edge after the operands are accepted. A held product must stay unchanged one edge after a cycle with `in_valid` low. The bench drives the inputs on falling edges and samples the outputs on the next falling edge. That sample point is one register stage after the capture, so each comparison lines up with the single output register. A behavioural model tracks the expected flag and the expected product, including the held value, and is compared with the design in every cycle. The stimulus mixes corner operands, idle gaps and random operands.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Selection produced by one recoding window.
    typedef struct packed {
        logic neg;   // multiple is negated
        logic two;   // magnitude 2A
        logic one;   // magnitude A
    } booth_sel_t;

    // Number of windows needed for an unsigned n-bit multiplier.
    function automatic int rows_for(input int n);
        return (n + 2) / 2;
    endfunction

    // Map one three-bit window {hi, mid, lo} onto a multiple of A.
    function automatic booth_sel_t decode_window(input logic [2:0] w);
        booth_sel_t s;
        s = '0;
        unique case (w)
            3'b000, 3'b111: s = '0;
            3'b001, 3'b010: s.one = 1'b1;
            3'b011:         s.two = 1'b1;
            3'b100:         begin s.neg = 1'b1; s.two = 1'b1; end
            3'b101, 3'b110: begin s.neg = 1'b1; s.one = 1'b1; end
            default:        s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
#(
    parameter int N = 64,
    localparam int ROWS = rows_for(N),
    localparam int BW   = 2 * ROWS
) (
    input  logic [N-1:0] b,
    output booth_sel_t   sel [ROWS]
);
    // zero-extended multiplier so the top window sees a positive value
    logic [BW-1:0] b_ext;
    assign b_ext = BW'(b);

    genvar gi;
    generate
        for (gi = 0; gi < ROWS; gi++) begin : g_win
            logic [2:0] win;
            if (gi == 0) begin : g_first
                assign win = {b_ext[1], b_ext[0], 1'b0};
            end else begin : g_rest
                assign win = {b_ext[2*gi+1], b_ext[2*gi], b_ext[2*gi-1]};
            end
            assign sel[gi] = decode_window(win);

            // R5: a window never asks for both magnitudes
            always_comb begin
                p_single_mag_r5: assert (!(sel[gi].one && sel[gi].two))
                    else $error("window %0d selects A and 2A", gi);
            end
        end
    endgenerate

endmodule

// File: rtl/booth_rows.sv
module booth_rows
    import booth_pkg::*;
#(
    parameter int N = 64,
    localparam int ROWS = rows_for(N),
    localparam int W    = 2 * N
) (
    input  logic [N-1:0]  a,
    input  booth_sel_t    sel  [ROWS],
    output logic [W-1:0]  row  [ROWS],
    output logic [W-1:0]  corr
);
    logic [W-1:0] a_w;
    assign a_w = W'(a);

    genvar gi;
    generate
        for (gi = 0; gi < ROWS; gi++) begin : g_row
            logic [W-1:0] mag;
            logic [W-1:0] signed_mag;
            always_comb begin
                if (sel[gi].two)      mag = a_w << 1;
                else if (sel[gi].one) mag = a_w;
                else                  mag = '0;
                // inversion extends the sign across all 2N bits
                signed_mag = sel[gi].neg ? ~mag : mag;
            end
            assign row[gi] = signed_mag << (2 * gi);
        end
    endgenerate

    // the +1 of every negated row lands at that row's weight 2i
    always_comb begin
        corr = '0;
        for (int i = 0; i < ROWS; i++) begin
            corr[2*i] = sel[i].neg;
        end
    end

endmodule

// File: rtl/csa_reduce.sv
module csa_reduce #(
    parameter int W   = 128,
    parameter int NUM = 34
) (
    input  logic [W-1:0] vec   [NUM],
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    // three-input, two-output compression applied row by row
    always_comb begin
        logic [W-1:0] s_acc;
        logic [W-1:0] c_acc;
        logic [W-1:0] s_nxt;
        logic [W-1:0] c_nxt;
        s_acc = '0;
        c_acc = '0;
        for (int k = 0; k < NUM; k++) begin
            s_nxt = s_acc ^ c_acc ^ vec[k];
            c_nxt = ((s_acc & c_acc) | (s_acc & vec[k]) | (c_acc & vec[k])) << 1;
            s_acc = s_nxt;
            c_acc = c_nxt;
        end
        sum   = s_acc;
        carry = c_acc;
    end

endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_pkg::*;
#(
    parameter int N = 64,
    localparam int ROWS = rows_for(N),
    localparam int W    = 2 * N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic         out_valid,
    output logic [W-1:0] p
);
    booth_sel_t   sel  [ROWS];
    logic [W-1:0] row  [ROWS];
    logic [W-1:0] corr;
    logic [W-1:0] vec  [ROWS+1];
    logic [W-1:0] cs_sum;
    logic [W-1:0] cs_carry;
    logic [W-1:0] prod_next;

    booth_recoder #(.N(N)) u_rec (
        .b   (b),
        .sel (sel)
    );

    booth_rows #(.N(N)) u_rows (
        .a    (a),
        .sel  (sel),
        .row  (row),
        .corr (corr)
    );

    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            vec[i] = row[i];
        end
        vec[ROWS] = corr;
    end

    csa_reduce #(.W(W), .NUM(ROWS + 1)) u_csa (
        .vec   (vec),
        .sum   (cs_sum),
        .carry (cs_carry)
    );

    // single carry-propagate adder, modulo 2^(2N)
    assign prod_next = cs_sum + cs_carry;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            p         <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                p <= prod_next;
            end
        end
    end

    // ---------------- assertions ----------------
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    logic [W-1:0] ref_prod;
    assign ref_prod = W'(a) * W'(b);

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && p == '0))
        else $error("reset did not clear outputs");

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == $past(in_valid)))
        else $error("out_valid not aligned to in_valid");

    p_exact_prod_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid) |-> (p == $past(ref_prod)))
        else $error("product mismatch");

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(in_valid)) |-> $stable(p))
        else $error("product changed without in_valid");

endmodule

// File: tb/booth_mul_tb.sv
module booth_mul_tb;
    localparam int N = 64;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic         out_valid;
    logic [W-1:0] p;

    int tests  = 0;
    int failed = 0;

    // reference state
    logic [W-1:0] exp_p;
    logic         exp_v;

    always #4 clk = ~clk;   // 125 MHz

    booth_mul #(.N(N)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .p         (p)
    );

    task automatic check(input string req);
        tests++;
        if (out_valid !== exp_v || p !== exp_p) begin
            failed++;
            $display("FAIL %s: out_valid=%0b p=%h expected out_valid=%0b p=%h",
                     req, out_valid, p, exp_v, exp_p);
        end
    endtask

    // drive on a falling edge, compare at the next falling edge
    task automatic apply(input logic v, input logic [N-1:0] av,
                         input logic [N-1:0] bv, input string req);
        in_valid = v;
        a        = av;
        b        = bv;
        exp_v    = v;
        if (v) exp_p = W'(av) * W'(bv);
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #(8 * 150000);
        failed++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        logic [N-1:0] corner [8];
        corner[0] = '0;
        corner[1] = N'(1);
        corner[2] = '1;
        corner[3] = {(N/2){2'b10}};
        corner[4] = {(N/2){2'b01}};
        corner[5] = {1'b1, {(N-1){1'b0}}};
        corner[6] = {{(N/2){1'b0}}, {(N/2){1'b1}}};
        corner[7] = {(N/4){4'b0111}};

        rst = 1'b1; in_valid = 1'b0; a = '0; b = '0;
        exp_v = 1'b0; exp_p = '0;
        @(negedge clk);
        // leave garbage on the inputs during reset
        in_valid = 1'b1; a = '1; b = '1;
        @(negedge clk);
        check("R1");
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1");

        // R3 basic values
        apply(1'b1, N'(3), N'(5), "R3");
        apply(1'b1, N'(12345), N'(678), "R3");
        // R4 idle cycles keep the product
        apply(1'b0, '1, '1, "R4");
        apply(1'b0, N'(7), N'(9), "R4");
        // R6 all-ones in both operands
        apply(1'b1, '1, '1, "R6");
        // R2 valid drops then returns
        apply(1'b0, '0, '0, "R2");
        apply(1'b1, '0, '1, "R2");
        // R5/R7 every corner pair
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                apply(1'b1, corner[i], corner[j], "R7");
            end
        end
        // R5 single windows of each code at several positions
        for (int k = 0; k < N/2; k++) begin
            for (int c = 1; c < 8; c++) begin
                apply(1'b1, corner[2] ^ N'(k), N'(c) << (2 * k) >> 1, "R5");
            end
        end
        // R3 random traffic with idle gaps
        for (int r = 0; r < 400; r++) begin
            logic [N-1:0] ra;
            logic [N-1:0] rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            apply(($urandom % 4) != 0, ra, rb, "R3");
        end
        // R1 reset mid-stream
        apply(1'b1, '1, N'(2), "R3");
        rst = 1'b1;
        in_valid = 1'b1;
        exp_v = 1'b0; exp_p = '0;
        @(negedge clk);
        check("R1");
        rst = 1'b0;
        apply(1'b0, '0, '0, "R4");

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule